// File: doc/BRIEF.md
# System Control Register File

This block holds thirty-two 32-bit system control registers that a processor pipeline addresses with a 5-bit index. A combinational read port returns whichever entry is selected. A write port stores a value into one entry. For a handful of entries, a write does more than store the value.

Writes to the status, cause and configuration entries pass through per-entry writable-bit masks. A status write also forces the coprocessor-usable and user-mode bits on. A write to the timer compare entry drops the highest hardware interrupt pending flag in cause. Six hardware interrupt lines set sticky pending flags in cause.

The status entry keeps a three-level stack of kernel/interrupt-enable pairs in its low six bits:
- Trap entry pushes the stack, records a 5-bit exception code in cause and captures the faulting program counter.
- A return-from-exception pops the stack.
- An operation aimed at the absent coprocessor 2 raises an unusable-coprocessor flag in the same cycle and enters a trap with code 11.

The reset input clears every entry. It asserts asynchronously and is expected to be released in step with the clock.

Top module: `sysctl_regfile`

## Requirements
- R1: `rd_data` shows, combinationally, the current content of the entry selected by `rd_idx`.
- R2: While `rst_n` is low, every one of the 32 entries reads as zero.
- R3: A write to any index other than 12 (status), 13 (cause), 14 (EPC) and 16 (config) stores `wr_data` unchanged on the next clock edge. A write to index 11 (compare) is also stored unchanged. A write to index 14 stores `wr_data` unchanged when no trap occurs in that cycle.
- R4: A write to index 12 stores `(wr_data & STATUS_WMASK) | STATUS_FORCE`. With the defaults, the mask is 0x0000FF3F and the forced bits are 29, 28 and 4 (0x30000010).
- R5: A write to index 13 stores `wr_data & CAUSE_WMASK`, with the default mask 0x00000300 (software interrupt bits 9:8).
- R6: A write to index 16 stores `wr_data & CONFIG_WMASK`, with the default mask 0x00000007.
- R7: A write to index 11 clears cause bit 15 in the same edge, and leaves the other cause bits as they were.
- R8: Each `irq_in[k]` high at a clock edge sets cause bit 10+k. The bit stays set until a cause write or a compare write (for bit 15) removes it. When a cause write and `irq_in` coincide, the interrupt bits are ORed into the masked value. When a compare write and `irq_in[5]` coincide, bit 15 ends up clear.
- R9: `rfe` makes the new status equal to old bits [31:4] with bits [3:0] taken from old bits [5:2].
- R10: Trap entry (`exc_valid` or `cp2_op`) makes the new status equal to old bits [31:6], then old bits [3:0], then two zero bits. It writes the trap code into cause bits [6:2] and leaves the other cause bits alone. It loads `exc_pc` into index 14.
- R11: `cu_fault` is high in exactly the cycles where `cp2_op` is high. A `cp2_op` with no `exc_valid` enters a trap with code 11. When both are high, the code is `exc_code`.
- R12: A trap takes priority over `rfe`, and `rfe` takes priority over a write. A write presented in a trap or `rfe` cycle is dropped entirely, including its compare side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Selected entry content |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write value before masking |
| rfe | input | 1 | Return-from-exception, pops the status stack |
| exc_valid | input | 1 | Trap entry strobe |
| exc_code | input | 5 | Trap code for cause bits [6:2] |
| exc_pc | input | 32 | Program counter captured into EPC on a trap |
| cp2_op | input | 1 | Operation aimed at the absent coprocessor 2 |
| irq_in | input | 6 | Hardware interrupt lines, set cause bits [15:10] |
| cu_fault | output | 1 | Unusable-coprocessor flag, same cycle as `cp2_op` |

## Verification
Directed patterns use all-ones and all-zeros write values on status, cause and config. These separate the mask from the forced bits, since each gives a distinct stored value.

A set-all-interrupts pass followed by a compare write shows that only bit 15 is cleared. Back-to-back trap and return sequences move distinct two-bit pairs through the stack. This exposes a pop or push that shifts by the wrong amount or drops the top pair.

Random cycles then mix writes, returns, traps, coprocessor-2 operations and interrupts, often in the same cycle. These cycles test the priority order and the ordering of the cause side effects against a bench model.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned CTL_W      = 32;
  localparam int unsigned CTL_IDX_W  = 5;
  localparam int unsigned CTL_DEPTH  = 1 << CTL_IDX_W;
  localparam int unsigned IRQ_N      = 6;
  localparam int unsigned IRQ_LO     = 10;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned CODE_LO    = 2;

  localparam logic [CTL_IDX_W-1:0] IDX_COMPARE = 5'd11;
  localparam logic [CTL_IDX_W-1:0] IDX_STATUS  = 5'd12;
  localparam logic [CTL_IDX_W-1:0] IDX_CAUSE   = 5'd13;
  localparam logic [CTL_IDX_W-1:0] IDX_EPC     = 5'd14;
  localparam logic [CTL_IDX_W-1:0] IDX_CONFIG  = 5'd16;

  localparam logic [CODE_W-1:0] CODE_COP_UNUSABLE = 5'd11;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_WRITE,
    ACT_RETURN,
    ACT_TRAP
  } ctl_act_e;
endpackage

// File: rtl/sysctl_entry.sv
module sysctl_entry
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CTL_W-1:0] nxt,
  output logic [CTL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/sysctl_wr_shaper.sv
module sysctl_wr_shaper
  import sysctl_pkg::*;
#(
  parameter logic [CTL_W-1:0] STATUS_WMASK = 32'h0000_FF3F,
  parameter logic [CTL_W-1:0] STATUS_FORCE = 32'h3000_0010,
  parameter logic [CTL_W-1:0] CAUSE_WMASK  = 32'h0000_0300,
  parameter logic [CTL_W-1:0] CONFIG_WMASK = 32'h0000_0007
) (
  input  logic [CTL_IDX_W-1:0] idx,
  input  logic [CTL_W-1:0]     raw,
  output logic [CTL_W-1:0]     shaped
);
  always_comb begin
    unique case (idx)
      IDX_STATUS: shaped = (raw & STATUS_WMASK) | STATUS_FORCE;
      IDX_CAUSE:  shaped = raw & CAUSE_WMASK;
      IDX_CONFIG: shaped = raw & CONFIG_WMASK;
      default:    shaped = raw;
    endcase
  end
endmodule

// File: rtl/sysctl_side_fx.sv
module sysctl_side_fx
  import sysctl_pkg::*;
(
  input  ctl_act_e             act,
  input  logic [CTL_IDX_W-1:0] wr_idx,
  input  logic [CTL_W-1:0]     shaped,
  input  logic [CODE_W-1:0]    trap_code,
  input  logic [IRQ_N-1:0]     irq_in,
  input  logic [CTL_W-1:0]     status_q,
  input  logic [CTL_W-1:0]     cause_q,
  output logic [CTL_W-1:0]     status_nxt,
  output logic [CTL_W-1:0]     cause_nxt
);
  localparam int unsigned IP_TOP = IRQ_LO + IRQ_N - 1;

  logic wr_status;
  logic wr_cause;
  logic wr_compare;

  assign wr_status  = (act == ACT_WRITE) && (wr_idx == IDX_STATUS);
  assign wr_cause   = (act == ACT_WRITE) && (wr_idx == IDX_CAUSE);
  assign wr_compare = (act == ACT_WRITE) && (wr_idx == IDX_COMPARE);

  // status stack: push on trap, pop on return
  always_comb begin
    status_nxt = status_q;
    if (act == ACT_TRAP) begin
      status_nxt = {status_q[CTL_W-1:6], status_q[3:0], 2'b00};
    end else if (act == ACT_RETURN) begin
      status_nxt = {status_q[CTL_W-1:4], status_q[5:2]};
    end else if (wr_status) begin
      status_nxt = shaped;
    end
  end

  // cause: write, trap code, interrupt set, compare clear (in that order)
  always_comb begin
    cause_nxt = cause_q;
    if (wr_cause) begin
      cause_nxt = shaped;
    end
    if (act == ACT_TRAP) begin
      cause_nxt[CODE_LO +: CODE_W] = trap_code;
    end
    cause_nxt[IRQ_LO +: IRQ_N] = cause_nxt[IRQ_LO +: IRQ_N] | irq_in;
    if (wr_compare) begin
      cause_nxt[IP_TOP] = 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] STATUS_WMASK = 32'h0000_FF3F,
  parameter logic [31:0] STATUS_FORCE = 32'h3000_0010,
  parameter logic [31:0] CAUSE_WMASK  = 32'h0000_0300,
  parameter logic [31:0] CONFIG_WMASK = 32'h0000_0007
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        rfe,
  input  logic        exc_valid,
  input  logic [4:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic        cp2_op,
  input  logic [5:0]  irq_in,
  output logic        cu_fault
);
  ctl_act_e         act;
  logic [CODE_W-1:0] trap_code;
  logic [CTL_W-1:0] shaped;
  logic [CTL_W-1:0] status_q;
  logic [CTL_W-1:0] cause_q;
  logic [CTL_W-1:0] status_nxt;
  logic [CTL_W-1:0] cause_nxt;
  logic [CTL_W-1:0] bank [CTL_DEPTH];
  logic             is_trap;
  logic             is_write;

  assign is_trap   = exc_valid | cp2_op;
  assign trap_code = exc_valid ? exc_code : CODE_COP_UNUSABLE;
  assign cu_fault  = cp2_op;

  always_comb begin
    if (is_trap)    act = ACT_TRAP;
    else if (rfe)   act = ACT_RETURN;
    else if (wr_en) act = ACT_WRITE;
    else            act = ACT_IDLE;
  end

  assign is_write = (act == ACT_WRITE);

  sysctl_wr_shaper #(
    .STATUS_WMASK (STATUS_WMASK),
    .STATUS_FORCE (STATUS_FORCE),
    .CAUSE_WMASK  (CAUSE_WMASK),
    .CONFIG_WMASK (CONFIG_WMASK)
  ) u_shaper (
    .idx    (wr_idx),
    .raw    (wr_data),
    .shaped (shaped)
  );

  sysctl_side_fx u_fx (
    .act        (act),
    .wr_idx     (wr_idx),
    .shaped     (shaped),
    .trap_code  (trap_code),
    .irq_in     (irq_in),
    .status_q   (status_q),
    .cause_q    (cause_q),
    .status_nxt (status_nxt),
    .cause_nxt  (cause_nxt)
  );

  for (genvar i = 0; i < CTL_DEPTH; i++) begin : g_entry
    logic             en;
    logic [CTL_W-1:0] nxt;
    logic [CTL_W-1:0] q;
    logic             hit;

    assign hit = is_write && (wr_idx == CTL_IDX_W'(i));

    if (CTL_IDX_W'(i) == IDX_STATUS) begin : g_status
      assign en  = (act == ACT_TRAP) || (act == ACT_RETURN) || hit;
      assign nxt = status_nxt;
    end else if (CTL_IDX_W'(i) == IDX_CAUSE) begin : g_cause
      assign en  = (act == ACT_TRAP) || hit || (|irq_in) ||
                   (is_write && (wr_idx == IDX_COMPARE));
      assign nxt = cause_nxt;
    end else if (CTL_IDX_W'(i) == IDX_EPC) begin : g_epc
      assign en  = (act == ACT_TRAP) || hit;
      assign nxt = (act == ACT_TRAP) ? exc_pc : shaped;
    end else begin : g_plain
      assign en  = hit;
      assign nxt = shaped;
    end

    sysctl_entry u_entry (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .nxt   (nxt),
      .q     (q)
    );

    assign bank[i] = q;
  end

  assign status_q = bank[IDX_STATUS];
  assign cause_q  = bank[IDX_CAUSE];
  assign rd_data  = bank[rd_idx];
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter logic [31:0] STATUS_FORCE = 32'h3000_0010,
  parameter logic [31:0] CAUSE_WMASK  = 32'h0000_0300
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic        rfe,
  input logic        exc_valid,
  input logic        cp2_op,
  input logic [5:0]  irq_in,
  input logic [31:0] status_q,
  input logic [31:0] cause_q
);
  logic wr_ok;
  assign wr_ok = wr_en && !rfe && !exc_valid && !cp2_op;

  AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wr_idx == IDX_STATUS |=> (status_q & STATUS_FORCE) == STATUS_FORCE); // R4

  AST_CAUSE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wr_idx == IDX_CAUSE && irq_in == '0 |=> (cause_q & ~CAUSE_WMASK) == '0); // R5

  AST_COMPARE_CLEARS_TOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wr_idx == IDX_COMPARE |=> !cause_q[15]); // R7

  AST_IRQ_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in[0] |=> cause_q[10]); // R8

  AST_RETURN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rfe && !exc_valid && !cp2_op |=>
      status_q[3:0] == $past(status_q[5:2]) && status_q[31:4] == $past(status_q[31:4])); // R9

  AST_TRAP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid || cp2_op |=> status_q[5:2] == $past(status_q[3:0]) && status_q[1:0] == 2'b00); // R10

  AST_CP2_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cp2_op && !exc_valid |=> cause_q[6:2] == CODE_COP_UNUSABLE); // R11
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .STATUS_FORCE (STATUS_FORCE),
  .CAUSE_WMASK  (CAUSE_WMASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .rfe       (rfe),
  .exc_valid (exc_valid),
  .cp2_op    (cp2_op),
  .irq_in    (irq_in),
  .status_q  (status_q),
  .cause_q   (cause_q)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  localparam logic [31:0] SMASK  = 32'h0000_FF3F;
  localparam logic [31:0] SFORCE = 32'h3000_0010;
  localparam logic [31:0] CMASK  = 32'h0000_0300;
  localparam logic [31:0] FMASK  = 32'h0000_0007;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rfe;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc;
  logic        cp2_op;
  logic [5:0]  irq_in;
  logic        cu_fault;

  int checks;
  int failures;
  bit done;
  logic [31:0] model [32];

  sysctl_regfile u_sysctl_regfile (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rfe(rfe),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc),
    .cp2_op(cp2_op), .irq_in(irq_in), .cu_fault(cu_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] shape(input logic [4:0] i, input logic [31:0] d);
    case (i)
      5'd12:   return (d & SMASK) | SFORCE;
      5'd13:   return d & CMASK;
      5'd16:   return d & FMASK;
      default: return d;
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                            input logic rf, input logic ex, input logic [4:0] ec,
                            input logic [31:0] pc, input logic cp, input logic [5:0] irq);
    logic [31:0] s;
    logic [31:0] c;
    s = model[12];
    c = model[13];
    if (ex || cp) begin
      s = {s[31:6], s[3:0], 2'b00};
      c[6:2] = ex ? ec : 5'd11;
      model[14] = pc;
    end else if (rf) begin
      s = {s[31:4], s[5:2]};
    end else if (we) begin
      if (wi == 5'd12) s = shape(wi, wd);
      else if (wi == 5'd13) c = shape(wi, wd);
      else model[wi] = shape(wi, wd);
    end
    c[15:10] = c[15:10] | irq;
    if (we && !rf && !ex && !cp && wi == 5'd11) c[15] = 1'b0;
    model[12] = s;
    model[13] = c;
  endtask

  task automatic check_reg(input logic [4:0] i, input string tag);
    rd_idx = i;
    #1;
    checks++;
    if (rd_data !== model[i]) begin
      failures++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", tag, i, rd_data, model[i]);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cycle(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                       input logic rf, input logic ex, input logic [4:0] ec,
                       input logic [31:0] pc, input logic cp, input logic [5:0] irq);
    wr_en = we; wr_idx = wi; wr_data = wd; rfe = rf;
    exc_valid = ex; exc_code = ec; exc_pc = pc; cp2_op = cp; irq_in = irq;
    #1;
    checks++;
    if (cu_fault !== cp) begin
      failures++;
      $display("FAIL R11 cu_fault actual=%b expected=%b", cu_fault, cp);
    end
    @(posedge clk);
    model_step(we, wi, wd, rf, ex, ec, pc, cp, irq);
    @(negedge clk);
    wr_en = 1'b0; rfe = 1'b0; exc_valid = 1'b0; cp2_op = 1'b0; irq_in = '0;
  endtask

  task automatic wr(input logic [4:0] wi, input logic [31:0] wd);
    cycle(1'b1, wi, wd, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 6'd0);
  endtask

  task automatic reset_and_check();
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) check_reg(5'(i), "R2 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rd_idx = '0; wr_en = 0; wr_idx = '0; wr_data = '0; rfe = 0;
    exc_valid = 0; exc_code = '0; exc_pc = '0; cp2_op = 0; irq_in = '0;
    void'($urandom(32'd1357));
    reset_and_check();

    // R1 / R3: plain entries and compare store unchanged
    wr(5'd5, 32'hDEAD_BEEF);   check_reg(5'd5, "R1 R3 plain write");
    wr(5'd31, 32'h8000_0001);  check_reg(5'd31, "R3 top index");
    wr(5'd11, 32'hFFFF_FFFF);  check_reg(5'd11, "R3 compare stored");
    check_reg(5'd5, "R1 other entry kept");

    // R4: status mask and forced bits
    wr(5'd12, 32'hFFFF_FFFF);  check_reg(5'd12, "R4 status ones");
    wr(5'd12, 32'h0000_0000);  check_reg(5'd12, "R4 status zeros");
    // R5 / R6
    wr(5'd13, 32'hFFFF_FFFF);  check_reg(5'd13, "R5 cause ones");
    wr(5'd16, 32'hFFFF_FFFF);  check_reg(5'd16, "R6 config ones");

    // R8 then R7: set all interrupt flags, compare clears only bit 15
    cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 6'h3F);
    check_reg(5'd13, "R8 irq set");
    wr(5'd11, 32'h0000_1234);  check_reg(5'd13, "R7 compare clears bit15");
    check_reg(5'd11, "R7 compare value");
    cycle(1'b1, 5'd11, 32'd7, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 6'h20);
    check_reg(5'd13, "R8 R7 compare beats irq5");

    // R10 / R9: push and pop with distinct pairs
    wr(5'd12, 32'h0000_0003);  check_reg(5'd12, "R4 status setup");
    cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 5'd8, 32'h0040_0100, 1'b0, 6'd0);
    check_reg(5'd12, "R10 push status");
    check_reg(5'd13, "R10 cause code");
    check_reg(5'd14, "R10 epc captured");
    cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 5'd4, 32'h0040_0200, 1'b0, 6'd0);
    check_reg(5'd12, "R10 second push");
    cycle(1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 5'd0, 32'd0, 1'b0, 6'd0);
    check_reg(5'd12, "R9 pop");
    cycle(1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 5'd0, 32'd0, 1'b0, 6'd0);
    check_reg(5'd12, "R9 second pop");

    // R11: coprocessor-2 access alone, then with exc_valid
    cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 5'd0, 32'h0000_0AB0, 1'b1, 6'd0);
    check_reg(5'd13, "R11 code 11");
    check_reg(5'd14, "R11 epc");
    cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 5'd13, 32'h0000_0AC0, 1'b1, 6'd0);
    check_reg(5'd13, "R11 exc_code wins");

    // R12: write dropped in trap and return cycles
    cycle(1'b1, 5'd7, 32'h1111_2222, 1'b0, 1'b1, 5'd2, 32'h0000_0B00, 1'b0, 6'd0);
    check_reg(5'd7, "R12 write dropped on trap");
    cycle(1'b1, 5'd11, 32'h3333_4444, 1'b1, 1'b0, 5'd0, 32'd0, 1'b0, 6'h20);
    check_reg(5'd11, "R12 compare dropped on rfe");
    check_reg(5'd13, "R12 no compare clear on rfe");
    check_reg(5'd12, "R12 rfe over write");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [4:0] wi;
      logic [4:0] pick;
      pick = 5'($urandom_range(0, 5));
      case (pick)
        5'd0: wi = 5'd11;
        5'd1: wi = 5'd12;
        5'd2: wi = 5'd13;
        5'd3: wi = 5'd14;
        5'd4: wi = 5'd16;
        default: wi = 5'($urandom);
      endcase
      cycle(1'($urandom), wi, $urandom, ($urandom % 6) == 0, ($urandom % 10) == 0,
            5'($urandom), $urandom, ($urandom % 12) == 0,
            (($urandom % 4) == 0) ? 6'($urandom) : 6'd0);
      check_reg(5'd12, "R12 random status");
      check_reg(5'd13, "R12 random cause");
      check_reg(5'($urandom), "R1 random read");
    end
    for (int i = 0; i < 32; i++) check_reg(5'(i), "R3 final sweep");

    reset_and_check();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule